// File: doc/BRIEF.md
# Timer Edge-Capture Unit

This block takes a snapshot of a free-running 16-bit timer count when a chosen transition appears on an external pin. The pin is asynchronous to the bus clock. It passes through a synchronizer chain, and then an edge detector whose polarity a control input selects. When a qualifying edge is found, the block loads the capture register, raises a capture flag and, if interrupts are enabled, drives an interrupt request. The counter itself is generated outside the block and supplied as an input.

The synchronizer adds delay. To compensate, the block stores the count as it stood at the clock edge just before the pin changed, plus one, and not the count at the time the edge is detected. Software reads the register one byte at a time. Reading the upper byte holds the lower byte, so that both halves come from the same event. The flag is cleared by a two-step handshake: a status read that finds the flag set, followed by a read of the lower byte.

Top module: `tmr_capture_unit`

## Requirements
- R1: With `riseSel` = 1, a 0-to-1 change on `capPin` causes a capture. A 1-to-0 change leaves `icf` clear and the captured value unchanged.
- R2: With `riseSel` = 0, a 1-to-0 change on `capPin` causes a capture.
- R3: The captured 16-bit value is the `cntVal` sampled at the last rising clock edge before the pin changed, plus one, modulo 2^16. So 0xFFFF gives 0x0000, and 0x00FF gives 0x0100.
- R4: The new value and `icf` = 1 first appear after the third rising clock edge that follows the pin change. After the second such edge they have not yet changed.
- R5: A qualifying edge overwrites the capture register even when `icf` is already set.
- R6: Every capture sets `icf`. `irq` is 1 exactly when `icf` is 1 and `intEn` is 1.
- R7: `icf` clears only when a `rdLo` pulse follows a `statusRd` pulse that was given while `icf` was 1. A `rdLo` with no such status read, or after a status read that found `icf` at 0, leaves `icf` set.
- R8: After a `rdHi` pulse, `capLoByte` holds the low byte as it was at that read, even across new captures, until a `rdLo` pulse. `capHiByte` always shows bits 15:8 of the latest capture.
- R9: Reset (`rstN` = 0) clears `icf` and `irq` but does not alter the captured value.
- R10: A pin level already present while reset is asserted never produces a capture. No capture can appear within the first SYNC_STAGES+1 clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capPin | input | 1 | Asynchronous external capture input |
| riseSel | input | 1 | Edge polarity: 1 = rising, 0 = falling |
| intEn | input | 1 | Capture interrupt enable |
| cntVal | input | 16 | Free-running counter value |
| statusRd | input | 1 | Status-read strobe (first step of flag clear) |
| rdHi | input | 1 | Upper-byte read strobe (freezes lower byte) |
| rdLo | input | 1 | Lower-byte read strobe (releases freeze, completes clear) |
| capHiByte | output | 8 | Captured value bits 15:8 |
| capLoByte | output | 8 | Captured value bits 7:0, or the frozen copy |
| icf | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
If the counter delay pipeline has the wrong depth, every captured value is off by a multiple of the input step. This shows on the byte outputs three cycles after each edge. A broken flag handshake shows up as `icf` either staying set or falling early, visible on the first clock after the `rdLo` strobe. A freeze fault becomes visible the first time a capture lands between the two byte reads, when `capLoByte` changes early or stays stale after the release. A synchronizer that is one stage long or short moves the edge at which `icf` rises by a single cycle.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  // Strobes from control to datapath, one clock wide each
  typedef struct packed {
    logic loadCap;     // copy delayed count + 1 into the capture register
    logic freezeLow;   // hold the current low byte
    logic releaseLow;  // let the low byte track the register again
  } capStrobe_t;

endpackage

// File: rtl/tcap_edge_det.sv
module tcap_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinAsync,
  input  logic riseSel,
  output logic edgeHit
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [SYNC_STAGES:0]   vldQ;   // pipeline-full tracker, reset only here

  always_ff @(posedge clk) begin
    syncQ[0] <= pinAsync;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      syncQ[i] <= syncQ[i-1];
    end
  end

  always_ff @(posedge clk) begin
    prevQ <= syncQ[LAST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldQ <= '0;
    else       vldQ <= {vldQ[SYNC_STAGES-1:0], 1'b1};
  end

  logic changed;
  logic polarityOk;

  always_comb begin
    changed    = syncQ[LAST] ^ prevQ;
    polarityOk = riseSel ? syncQ[LAST] : prevQ;
    edgeHit    = vldQ[SYNC_STAGES] & changed & polarityOk;
  end

endmodule

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  capStrobe_t       strobe,
  output logic [CNT_W-1:0] capValue,
  output logic [CNT_W/2-1:0] capLoByte
);

  localparam int BYTE_W = CNT_W / 2;
  localparam int DEPTH  = SYNC_STAGES + 1;

  // Count history aligned with the synchronizer so the tap matches the
  // clock edge just before the pin moved
  logic [CNT_W-1:0] cntPipe [DEPTH];

  always_ff @(posedge clk) begin
    cntPipe[0] <= cntVal;
    for (int j = 1; j < DEPTH; j++) begin
      cntPipe[j] <= cntPipe[j-1];
    end
  end

  // Capture register: deliberately without reset
  logic [CNT_W-1:0] capReg;

  always_ff @(posedge clk) begin
    if (strobe.loadCap) capReg <= cntPipe[DEPTH-1] + CNT_W'(1);
  end

  logic [BYTE_W-1:0] lowHold;
  logic              frozenQ;

  always_ff @(posedge clk) begin
    if (strobe.freezeLow) lowHold <= capReg[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  frozenQ <= 1'b0;
    else if (strobe.freezeLow)  frozenQ <= 1'b1;
    else if (strobe.releaseLow) frozenQ <= 1'b0;
  end

  always_comb begin
    capValue  = capReg;
    capLoByte = frozenQ ? lowHold : capReg[BYTE_W-1:0];
  end

endmodule

// File: rtl/tcap_control.sv
module tcap_control
  import tcap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       edgeHit,
  input  logic       statusRd,
  input  logic       rdHi,
  input  logic       rdLo,
  input  logic       intEn,
  output capStrobe_t strobe,
  output logic       icf,
  output logic       irq
);

  logic icfQ;
  logic armQ;    // a status read has seen the flag set
  logic clrNow;

  always_comb begin
    clrNow            = armQ & rdLo;
    strobe.loadCap    = edgeHit;
    strobe.freezeLow  = rdHi;
    strobe.releaseLow = rdLo & ~rdHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      icfQ <= 1'b0;
      armQ <= 1'b0;
    end else begin
      // a capture in the same cycle as the clear wins
      if (edgeHit)     icfQ <= 1'b1;
      else if (clrNow) icfQ <= 1'b0;

      if (clrNow)                armQ <= 1'b0;
      else if (statusRd && icfQ) armQ <= 1'b1;
    end
  end

  always_comb begin
    icf = icfQ;
    irq = icfQ & intEn;
  end

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capPin,
  input  logic               riseSel,
  input  logic               intEn,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic               statusRd,
  input  logic               rdHi,
  input  logic               rdLo,
  output logic [CNT_W/2-1:0] capHiByte,
  output logic [CNT_W/2-1:0] capLoByte,
  output logic               icf,
  output logic               irq
);

  localparam int BYTE_W = CNT_W / 2;

  logic             edgeHit;
  capStrobe_t       strobe;
  logic [CNT_W-1:0] capValue;

  tcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk      (clk),
    .rstN     (rstN),
    .pinAsync (capPin),
    .riseSel  (riseSel),
    .edgeHit  (edgeHit)
  );

  tcap_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .edgeHit  (edgeHit),
    .statusRd (statusRd),
    .rdHi     (rdHi),
    .rdLo     (rdLo),
    .intEn    (intEn),
    .strobe   (strobe),
    .icf      (icf),
    .irq      (irq)
  );

  tcap_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cntVal    (cntVal),
    .strobe    (strobe),
    .capValue  (capValue),
    .capLoByte (capLoByte)
  );

  assign capHiByte = capValue[CNT_W-1:BYTE_W];

endmodule

// File: rtl/tcap_checker.sv
module tcap_checker #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [CNT_W-1:0]   cntVal,
  input logic [CNT_W-1:0]   capValue,
  input logic [CNT_W/2-1:0] capLoByte,
  input logic               icf,
  input logic               rdHi,
  input logic               rdLo
);

  localparam int QUIET = SYNC_STAGES + 1;

  logic hiPend;
  int   sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      hiPend <= 1'b0;
    else if (rdHi)  hiPend <= 1'b1;
    else if (rdLo)  hiPend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceRst <= 0;
    else if (sinceRst <= QUIET) sinceRst <= sinceRst + 1;
  end

  // R9
  icf_reset_chk: assert property (@(posedge clk) !rstN |=> !icf);

  // R10
  no_early_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst <= QUIET) |-> !icf);

  // R3
  capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(icf) |-> (capValue == CNT_W'($past(cntVal, SYNC_STAGES + 2) + CNT_W'(1))));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (icf && !rdLo) |=> icf);

  // R8
  low_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hiPend && !rdHi && !rdLo) |=> $stable(capLoByte));

endmodule

bind tmr_capture_unit tcap_checker #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cntVal    (cntVal),
  .capValue  (capValue),
  .capLoByte (capLoByte),
  .icf       (icf),
  .rdHi      (rdHi),
  .rdLo      (rdLo)
);

// File: tb/tmr_capture_unit_tb_top.sv
module tmr_capture_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;   // SYNC_STAGES + 1 edges from pin change to result

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capPin = 1'b1;
  logic        riseSel = 1'b1;
  logic        intEn = 1'b1;
  logic [15:0] cntVal = 16'h1230;
  logic        statusRd = 1'b0;
  logic        rdHi = 1'b0;
  logic        rdLo = 1'b0;
  logic [7:0]  capHiByte;
  logic [7:0]  capLoByte;
  logic        icf;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_capture_unit dut_i (
    .clk(clk), .rstN(rstN), .capPin(capPin), .riseSel(riseSel), .intEn(intEn),
    .cntVal(cntVal), .statusRd(statusRd), .rdHi(rdHi), .rdLo(rdLo),
    .capHiByte(capHiByte), .capLoByte(capLoByte), .icf(icf), .irq(irq)
  );

  int          cycle = 0;
  logic [15:0] lastCnt = '0;
  always @(posedge clk) begin
    cycle++;
    lastCnt = cntVal;
  end

  bit cntRun = 1'b1;
  int divCnt = 0;
  always @(negedge clk) begin
    if (cntRun) begin
      divCnt++;
      if (divCnt == 4) begin
        divCnt = 0;
        cntVal = cntVal + 16'd1;
      end
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    logic [15:0] val;
    int          due;
    bit          hiOnly;
    string       tag;
  } expItem_t;

  expItem_t    sbq[$];
  logic [15:0] lastExp = '0;

  // Monitor: compares results in the cycle they are due
  always @(negedge clk) begin
    if (sbq.size() > 0 && cycle == sbq[0].due) begin
      expItem_t it;
      it = sbq.pop_front();
      chk(capHiByte == it.val[15:8], it.tag, "high byte", capHiByte, it.val[15:8]);
      if (!it.hiOnly)
        chk(capLoByte == it.val[7:0], it.tag, "low byte", capLoByte, it.val[7:0]);
      chk(icf == 1'b1, it.tag, "flag after capture (R6)", icf, 1);
      chk(irq == intEn, it.tag, "irq vs enable (R6)", irq, intEn);
    end
  end

  // Driver: moves the pin and predicts the result
  task automatic pinTo(bit v, bit hiOnly, string tag);
    @(negedge clk);
    if (v != capPin && v == riseSel) begin
      expItem_t it;
      it.val    = lastCnt + 16'd1;
      it.due    = cycle + LAT;
      it.hiOnly = hiOnly;
      it.tag    = tag;
      sbq.push_back(it);
      lastExp = it.val;
    end
    capPin = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic statusRead();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  task automatic readHi();
    @(negedge clk); rdHi = 1'b1;
    @(negedge clk); rdHi = 1'b0;
  endtask

  task automatic readLo();
    @(negedge clk); rdLo = 1'b1;
    @(negedge clk); rdLo = 1'b0;
  endtask

  task automatic clearFlag();
    statusRead();
    readLo();
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    logic [15:0] prevVal;
    logic [15:0] frozenA;

    // Reset with the pin already high and rising selected
    idle(3);
    rstN = 1'b1;
    idle(8);
    chk(icf == 1'b0, "R10", "no capture from level at reset", icf, 0);
    chk(irq == 1'b0, "R9", "irq after reset", irq, 0);

    // R1: falling edge ignored while rising is selected
    pinTo(1'b0, 1'b0, "R1");
    idle(6);
    chk(icf == 1'b0, "R1", "flag after wrong-polarity edge", icf, 0);

    // R1: rising edge captures
    pinTo(1'b1, 1'b0, "R1");
    idle(6);
    chk(irq == 1'b1, "R6", "irq with flag and enable", irq, 1);

    // R7: lower read alone does not clear
    readLo();
    chk(icf == 1'b1, "R7", "flag after lone low read", icf, 1);
    clearFlag();
    chk(icf == 1'b0, "R7", "flag after status+low read", icf, 0);

    // R7: a status read that saw the flag clear does not arm
    statusRead();
    pinTo(1'b0, 1'b0, "R1");
    pinTo(1'b1, 1'b0, "R1");
    idle(5);
    readLo();
    chk(icf == 1'b1, "R7", "flag after unarmed low read", icf, 1);
    clearFlag();
    chk(icf == 1'b0, "R7", "flag cleared", icf, 0);

    // R2 + R4: falling polarity and latency
    riseSel = 1'b0;
    prevVal = lastExp;
    pinTo(1'b0, 1'b0, "R2");
    idle(2);
    chk(icf == 1'b0, "R4", "flag two edges after change", icf, 0);
    chk({capHiByte, capLoByte} == prevVal, "R4", "value two edges after change",
        {capHiByte, capLoByte}, prevVal);
    idle(1);
    chk(icf == 1'b1, "R4", "flag three edges after change", icf, 1);
    idle(3);

    // R5: overwrite while the flag is still set
    pinTo(1'b1, 1'b0, "R5");
    idle(3);
    pinTo(1'b0, 1'b0, "R5");
    idle(6);
    clearFlag();

    // R8: upper read freezes lower byte across a new capture
    frozenA = lastExp;
    readHi();
    pinTo(1'b1, 1'b0, "R8");
    idle(4);
    pinTo(1'b0, 1'b1, "R8");
    idle(6);
    chk(capLoByte == frozenA[7:0], "R8", "frozen low byte", capLoByte, frozenA[7:0]);
    readLo();
    chk(capLoByte == lastExp[7:0], "R8", "low byte after release", capLoByte, lastExp[7:0]);
    clearFlag();

    // R3: wrap and carry into the upper byte
    cntRun = 1'b0;
    cntVal = 16'hFFFF;
    idle(2);
    pinTo(1'b1, 1'b0, "R3");
    idle(2);
    pinTo(1'b0, 1'b0, "R3");
    idle(6);
    chk(lastExp == 16'h0000, "R3", "predicted wrap value", lastExp, 0);
    cntVal = 16'h00FF;
    idle(2);
    pinTo(1'b1, 1'b0, "R3");
    idle(2);
    pinTo(1'b0, 1'b0, "R3");
    idle(6);
    chk({capHiByte, capLoByte} == 16'h0100, "R3", "carry into high byte",
        {capHiByte, capLoByte}, 16'h0100);
    cntRun = 1'b1;

    // R6: enable off masks the request
    intEn = 1'b0;
    idle(1);
    chk(icf == 1'b1 && irq == 1'b0, "R6", "irq with enable off", irq, 0);
    intEn = 1'b1;

    // R9: reset keeps the captured value
    prevVal = lastExp;
    rstN = 1'b0;
    idle(2);
    chk(icf == 1'b0, "R9", "flag during reset", icf, 0);
    chk({capHiByte, capLoByte} == prevVal, "R9", "value across reset",
        {capHiByte, capLoByte}, prevVal);
    rstN = 1'b1;
    idle(6);
    chk(icf == 1'b0, "R10", "no capture after reset release", icf, 0);

    while (sbq.size() > 0) idle(1);
    idle(2);
    finishRun();
  end

endmodule